// File: doc/BRIEF.md
# RS-485 Multidrop Address-Filtering Receiver

This block receives nine-bit asynchronous characters from a shared RS-485 bus. In each character the ninth bit, sent where a parity bit would normally sit, tells the two kinds of character apart. A one marks an address and a zero marks data. The receiver oversamples the line with a baud tick at sixteen times the bit rate. It rejects short low pulses that do not last to the middle of a start bit, and it checks the stop bit. Characters that pass are written into a small first-word-fall-through FIFO. Each FIFO entry holds the ninth bit above the eight data bits.

A two-bit mode input sets the acceptance rule. In the pass-through codes every good character is stored. In normal multidrop mode, the receive-off input decides whether data that arrives before the first address is thrown away. An address character opens reception and is stored. In automatic address mode the hardware compares each address with a programmed match value. A match opens reception and a mismatch closes it, and the address itself is never stored. Once reception is open or closed, that state holds until another address character or a change of mode. The `rxOpen` output shows whether a data character would be accepted at that moment.

Top module: `mdrop_rx`

## Requirements
- R1: After reset the FIFO is empty (`fifoEmpty`=1, `fifoFull`=0), `overrun`=0 and `frameErr`=0.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, a ninth bit and one high stop bit, each lasting 16 baud ticks. With `cfgMode` 2'b00 or 2'b11, every good frame is stored as `rdData[8]`=ninth bit and `rdData[7:0]`=data.
- R3: A low level that has returned high by the 8th baud tick after it was first seen is not taken as a start bit. It stores nothing and raises no framing error.
- R4: A frame whose stop bit is sampled low raises `frameErr` for exactly one clock. The frame is not stored and the acceptance state does not change. The receiver then waits for the line to go high before it looks for the next start bit.
- R5: In normal multidrop mode (`cfgMode`=2'b01) with `cfgRxOff`=1, data characters are discarded and `rxOpen`=0 until an address character arrives.
- R6: In normal multidrop mode an address character is stored and sets `rxOpen`=1. Data characters that follow are then stored.
- R7: In normal multidrop mode with `cfgRxOff`=0, data characters are stored even before any address has arrived, and `rxOpen`=1.
- R8: In automatic address mode (`cfgMode`=2'b10) an address equal to `cfgMatchAddr` sets `rxOpen`=1 and is not stored. Data that follows is stored.
- R9: In automatic address mode an address that differs from `cfgMatchAddr` sets `rxOpen`=0 and is not stored. While reception is closed, data is discarded.
- R10: An accepted character that arrives while the FIFO is full is dropped, and `overrun` is set. It stays set until reset.
- R11: Any change of `cfgMode` closes reception, so the acceptance state starts from closed in the new mode.
- R12: `rdData` shows the oldest entry while `fifoEmpty`=0. A one-clock `popEn` removes that entry, and entries come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-clock enable at 16x the bit rate |
| rxLine | input | 1 | Serial line, idle high |
| cfgMode | input | 2 | 00/11 pass-through, 01 normal multidrop, 10 automatic address |
| cfgRxOff | input | 1 | Discard data before the first address (normal multidrop) |
| cfgMatchAddr | input | 8 | Station address for automatic address mode |
| popEn | input | 1 | Remove the FIFO head |
| rdData | output | 9 | FIFO head: ninth bit, then data |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoFull | output | 1 | FIFO holds DEPTH entries |
| overrun | output | 1 | Sticky: an accepted character was dropped |
| frameErr | output | 1 | One-clock pulse on a bad stop bit |
| rxOpen | output | 1 | A data character would be accepted now |

## Verification
Character streams that mix address and data characters are sent in every mode. Each stream pairs a data character before any address, a matching address and a non-matching address with data that follows them. This separates the open and closed states and shows whether an address is stored. Frames with a low stop bit are sent while reception is open and while it is closed. They show that an error neither writes the FIFO nor moves the acceptance state. A short low glitch tells start-bit validation apart from plain edge detection. A burst longer than the FIFO depth shows the overrun drop and that `overrun` stays set.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  // Acceptance rule selected by cfgMode.
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_NMM   = 2'b01,
    MODE_AAD   = 2'b10,
    MODE_DIR   = 2'b11
  } rxMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP,
    ST_WAITHI
  } rxState_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic shift;
    logic push;
  } rxStrb_t;

endpackage

// File: rtl/mdrop_rx_dp.sv
module mdrop_rx_dp
  import mdrop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrb_t           strb,
  input  logic              popEn,
  output logic              rxBit,
  output logic [DATA_W:0]   frame,
  output logic [DATA_W:0]   rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              overrun
);
  localparam int FW = DATA_W + 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FW-1:0]          frameQ;
  logic [FW-1:0]          mem [DEPTH];
  logic [AW-1:0]          wrPtr, rdPtr;
  logic [AW:0]            cnt;
  logic                   doPop, doPush;

  // Line synchronizer; it resets to idle-high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = syncQ[SYNC_STAGES-1];

  // Bits arrive least significant first; the ninth bit ends up at the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           frameQ <= '0;
    else if (strb.shift) frameQ <= {rxBit, frameQ[FW-1:1]};
  end
  assign frame = frameQ;

  assign fifoEmpty = (cnt == '0);
  assign fifoFull  = (cnt == (AW+1)'(DEPTH));
  assign doPop     = popEn && !fifoEmpty;
  assign doPush    = strb.push && (!fifoFull || doPop);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= frameQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (strb.push && !doPush) overrun <= 1'b1;
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/mdrop_rx_ctl.sv
module mdrop_rx_ctl
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxBit,
  input  logic [DATA_W:0]   frame,
  input  logic [1:0]        cfgMode,
  input  logic              cfgRxOff,
  input  logic [DATA_W-1:0] cfgMatchAddr,
  output rxStrb_t           strb,
  output logic              frameErr,
  output logic              rxOpen
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W);

  rxState_e      state;
  rxMode_e       mode, modeQ;
  logic [CW-1:0] osCnt;
  logic [BW-1:0] bitCnt;
  logic          openQ;
  logic          midStop, done, isAddr, addrHit, store;

  assign mode    = rxMode_e'(cfgMode);
  assign midStop = baudTick && (state == ST_STOP) && (osCnt == FULL_LAST);
  assign done    = midStop && rxBit;
  assign isAddr  = frame[DATA_W];
  assign addrHit = (frame[DATA_W-1:0] == cfgMatchAddr);

  always_comb begin
    case (mode)
      MODE_NMM: store = isAddr || openQ || !cfgRxOff;
      MODE_AAD: store = !isAddr && openQ;
      default:  store = 1'b1;
    endcase
  end

  always_comb begin
    strb.shift = baudTick && (state == ST_BITS) && (osCnt == FULL_LAST);
    strb.push  = done && store && (mode == modeQ);
  end

  always_comb begin
    case (mode)
      MODE_NMM: rxOpen = openQ || !cfgRxOff;
      MODE_AAD: rxOpen = openQ;
      default:  rxOpen = 1'b1;
    endcase
  end

  // Frame sequencer, advancing only on baud ticks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      osCnt    <= '0;
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= 1'b0;
      if (baudTick) begin
        case (state)
          ST_IDLE: begin
            osCnt <= '0;
            if (!rxBit) state <= ST_START;
          end
          ST_START: begin
            if (osCnt == HALF_LAST) begin
              osCnt  <= '0;
              bitCnt <= '0;
              state  <= rxBit ? ST_IDLE : ST_BITS;
            end else osCnt <= osCnt + 1'b1;
          end
          ST_BITS: begin
            osCnt <= osCnt + 1'b1;
            if (osCnt == FULL_LAST) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) state <= ST_STOP;
            end
          end
          ST_STOP: begin
            osCnt <= osCnt + 1'b1;
            if (osCnt == FULL_LAST) begin
              state <= rxBit ? ST_IDLE : ST_WAITHI;
              if (!rxBit) frameErr <= 1'b1;
            end
          end
          default: if (rxBit) state <= ST_IDLE;
        endcase
      end
    end
  end

  // Acceptance state: set by address characters, cleared by a mode change.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_PLAIN;
      openQ <= 1'b0;
    end else begin
      modeQ <= mode;
      if (mode != modeQ)           openQ <= 1'b0;
      else if (done && isAddr) begin
        if (mode == MODE_NMM)      openQ <= 1'b1;
        else if (mode == MODE_AAD) openQ <= addrHit;
      end
    end
  end

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic [1:0]        cfgMode,
  input  logic              cfgRxOff,
  input  logic [DATA_W-1:0] cfgMatchAddr,
  input  logic              popEn,
  output logic [DATA_W:0]   rdData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              overrun,
  output logic              frameErr,
  output logic              rxOpen
);
  rxStrb_t         strbW;
  logic            rxBitW;
  logic [DATA_W:0] frameW;

  mdrop_rx_ctl #(.DATA_W(DATA_W), .OSR(OSR)) uCtl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxBit(rxBitW),
    .frame(frameW), .cfgMode(cfgMode), .cfgRxOff(cfgRxOff),
    .cfgMatchAddr(cfgMatchAddr), .strb(strbW), .frameErr(frameErr),
    .rxOpen(rxOpen)
  );

  mdrop_rx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strb(strbW), .popEn(popEn),
    .rxBit(rxBitW), .frame(frameW), .rdData(rdData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .overrun(overrun)
  );

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      cfgMode,
  input logic            cfgRxOff,
  input logic            fifoEmpty,
  input logic            fifoFull,
  input logic            overrun,
  input logic            frameErr,
  input logic            rxOpen,
  input logic            push,
  input logic [DATA_W:0] pushData
);

  a_r1_empty_full_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  a_r4_ferr_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);

  a_r4_no_push_after_ferr: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !push);

  a_r5_closed_only_addr: assert property (@(posedge clk) disable iff (!rstN)
    (push && cfgMode == 2'b01 && cfgRxOff) |-> (pushData[DATA_W] || rxOpen));

  a_r8_addr_not_stored: assert property (@(posedge clk) disable iff (!rstN)
    (push && cfgMode == 2'b10) |-> !pushData[DATA_W]);

  a_r9_push_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    (push && cfgMode == 2'b10) |-> rxOpen);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  a_r10_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(fifoFull));

endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgRxOff(cfgRxOff),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .overrun(overrun),
  .frameErr(frameErr), .rxOpen(rxOpen), .push(strbW.push),
  .pushData(frameW)
);

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int TICKDIV = 4;
  localparam int BITCLK = 16 * TICKDIV;

  logic clk = 1'b0, rstN = 1'b0, baudTick = 1'b0, rxLine = 1'b1;
  logic [1:0] cfgMode = 2'b00;
  logic cfgRxOff = 1'b0, popEn = 1'b0;
  logic [7:0] cfgMatchAddr = 8'h00;
  logic [8:0] rdData;
  logic fifoEmpty, fifoFull, overrun, frameErr, rxOpen;

  int checks = 0, failures = 0, ferrSeen = 0, cycles = 0, tickCnt = 0;
  bit finished = 0;

  // Behavioural reference state.
  logic [8:0] q[$];
  bit mOpen = 0, mOvr = 0;
  int mFerr = 0;

  mdrop_rx uut (.clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .cfgMode(cfgMode), .cfgRxOff(cfgRxOff), .cfgMatchAddr(cfgMatchAddr),
    .popEn(popEn), .rdData(rdData), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .overrun(overrun), .frameErr(frameErr), .rxOpen(rxOpen));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICKDIV-1) ? 0 : tickCnt + 1;
    baudTick <= (tickCnt == TICKDIV-1);
  end

  always @(posedge clk) if (rstN && frameErr) ferrSeen++;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finishRun();
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expOpen();
    case (cfgMode)
      2'b01: return mOpen || !cfgRxOff;
      2'b10: return mOpen;
      default: return 1'b1;
    endcase
  endfunction

  task automatic modelFrame(logic [8:0] v, bit stopOk);
    bit isA, st;
    if (!stopOk) begin mFerr++; return; end
    isA = v[8];
    case (cfgMode)
      2'b01: begin st = isA || mOpen || !cfgRxOff; if (isA) mOpen = 1; end
      2'b10: begin st = !isA && mOpen; if (isA) mOpen = (v[7:0] == cfgMatchAddr); end
      default: st = 1;
    endcase
    if (st) begin
      if (q.size() < DEPTH) q.push_back(v);
      else mOvr = 1;
    end
  endtask

  task automatic sendFrame(logic [8:0] v, bit stopOk);
    @(negedge clk) rxLine = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rxLine = v[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxLine = stopOk;
    repeat (BITCLK) @(negedge clk);
    rxLine = 1'b1;
    repeat (BITCLK/2) @(negedge clk);
    modelFrame(v, stopOk);
  endtask

  task automatic compareState(string req);
    check({req, " fifoEmpty"}, fifoEmpty, q.size() == 0);
    check({req, " fifoFull"}, fifoFull, q.size() == DEPTH);
    check({req, " overrun"}, overrun, mOvr);
    check({req, " rxOpen"}, rxOpen, expOpen());
    check({req, " frameErr count"}, ferrSeen, mFerr);
  endtask

  task automatic drain(string req);
    while (q.size() > 0) begin
      @(negedge clk);
      check({req, " R12 not empty"}, fifoEmpty, 0);
      check({req, " R12 head"}, rdData, q[0]);
      popEn = 1'b1;
      @(negedge clk) popEn = 1'b0;
      void'(q.pop_front());
    end
    @(negedge clk);
    check({req, " R12 empty after drain"}, fifoEmpty, 1);
  endtask

  task automatic setCfg(logic [1:0] m, bit off, logic [7:0] match);
    @(negedge clk);
    if (m != cfgMode) mOpen = 0;
    cfgMode = m; cfgRxOff = off; cfgMatchAddr = match;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 fifoEmpty", fifoEmpty, 1);
    check("R1 fifoFull", fifoFull, 0);
    check("R1 overrun", overrun, 0);
    check("R1 frameErr", frameErr, 0);

    // R2 pass-through codes store everything
    sendFrame(9'h05C, 1); sendFrame(9'h181, 1);
    compareState("R2 plain");
    drain("R2 plain");
    setCfg(2'b11, 0, 8'h00);
    sendFrame(9'h1A5, 1); sendFrame(9'h03C, 1);
    compareState("R2 code11");
    drain("R2 code11");

    // R3 short glitch
    @(negedge clk) rxLine = 1'b0;
    repeat (2*TICKDIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (4*BITCLK) @(negedge clk);
    compareState("R3 glitch");
    sendFrame(9'h0E7, 1);
    compareState("R3 recovery");
    drain("R3");

    // R4 bad stop in pass-through
    sendFrame(9'h055, 0);
    compareState("R4 plain ferr");

    // R5/R6 normal multidrop, receive-off
    setCfg(2'b01, 1, 8'h00);
    compareState("R5 closed");
    sendFrame(9'h011, 1);
    compareState("R5 data dropped");
    sendFrame(9'h142, 1);
    compareState("R6 addr opens");
    sendFrame(9'h022, 1);
    sendFrame(9'h099, 0);
    compareState("R4 ferr keeps open");
    drain("R6");

    // R11 mode change closes
    setCfg(2'b00, 1, 8'h00);
    setCfg(2'b01, 1, 8'h00);
    compareState("R11 reopen closed");
    sendFrame(9'h033, 1);
    compareState("R11 data dropped");

    // R7 receive-off cleared
    setCfg(2'b01, 0, 8'h00);
    sendFrame(9'h044, 1);
    compareState("R7 stored before addr");
    drain("R7");

    // R8/R9 automatic address
    setCfg(2'b10, 0, 8'h5A);
    compareState("R8 closed at entry");
    sendFrame(9'h066, 1);
    sendFrame(9'h133, 1);
    compareState("R9 mismatch stays closed");
    sendFrame(9'h15A, 1);
    compareState("R8 match opens, not stored");
    sendFrame(9'h077, 1);
    sendFrame(9'h0AB, 0);
    compareState("R4 ferr in AAD");
    sendFrame(9'h112, 1);
    compareState("R9 mismatch closes");
    sendFrame(9'h088, 1);
    compareState("R9 data dropped");
    drain("R8");

    // R10 overrun
    setCfg(2'b00, 0, 8'h00);
    for (int i = 0; i < DEPTH + 1; i++) sendFrame(9'(8'h10 + i), 1);
    compareState("R10 overflow");
    drain("R10");
    compareState("R10 sticky");

    finishRun();
  end
endmodule